// File: doc/BRIEF.md
# Lowest-Set-Bit Clear Execution Unit

This execution unit sits in a processor datapath. It takes a source operand and returns a copy of it with the least significant one-bit cleared. Along with the result it produces the arithmetic status flags and a mask that marks which of those flags carry a defined value.

The unit also checks the encoding and the processor mode before the operation may run. The operand is 64 bits wide only when the core is in 64-bit mode and the width bit of the encoding is set. In every other case the operation works on 32 bits. A set vector-length bit is an illegal encoding. Execution in real mode or virtual-8086 mode is also not allowed. Either condition raises an undefined-opcode exception and suppresses the result and the flag write.

The outputs are registered. A request marked valid on one clock edge appears as a valid result on the next edge.

Top module: `lsb_clear_unit`

## Requirements
- R1: In 64-bit operation, resultData equals srcOperand AND (srcOperand - 1). Every bit is kept except the lowest set bit, which becomes 0.
- R2: In 32-bit operation, only srcOperand[31:0] is used. resultData[31:0] is that value AND (that value - 1), and resultData[63:32] is zero.
- R3: The operand size is 64 bits only when longMode=1 and widthBit=1. widthBit has no effect when longMode=0.
- R4: flagsOut[0] (carry) is 1 exactly when the source at the active operand size is zero.
- R5: flagsOut[1] (zero) is 1 when the result at the active size is zero. flagsOut[2] (sign) is result bit 63 in 64-bit operation and result bit 31 in 32-bit operation.
- R6: flagsOut[3] (overflow) is always 0. flagsDefined is 6'b001111 for a legal operation, so bit 4 (auxiliary carry) and bit 5 (parity) are marked undefined.
- R7: When vecLenBit=1, excUndef is 1 and resultData, flagsOut and flagsDefined are all zero.
- R8: When legacyMode=1 (real or virtual-8086 mode), excUndef is 1 and resultData, flagsOut and flagsDefined are all zero.
- R9: outValid is 1 on the clock edge after an edge that sampled inValid=1, and 0 after an edge that sampled inValid=0.
- R10: A synchronous reset clears outValid and excUndef.
- R11: A zero source gives a zero result with both carry and zero set. A source with only its top bit set gives zero with carry clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| srcOperand | input | 64 | Source operand |
| longMode | input | 1 | Core is in 64-bit mode |
| legacyMode | input | 1 | Core is in real or virtual-8086 mode |
| widthBit | input | 1 | Encoding bit requesting 64-bit operand size |
| vecLenBit | input | 1 | Encoding vector-length bit; must be 0 |
| outValid | output | 1 | Result valid |
| resultData | output | 64 | Source with lowest set bit cleared |
| flagsOut | output | 6 | Flag values: 0 carry, 1 zero, 2 sign, 3 overflow, 4 aux, 5 parity |
| flagsDefined | output | 6 | Per-flag mask, 1 = value is defined |
| excUndef | output | 1 | Undefined-opcode exception |

## Verification
A wrong operand-size decision shows up at the ports on the very next valid result. In that case the upper result half is nonzero in 32-bit operation, or the sign flag comes from the wrong bit. A stale or mis-latched fault strobe appears one cycle later: either an exception arrives with a nonzero result or nonzero flag mask, or a legal request comes back with excUndef set. A broken valid pipeline appears as an outValid that comes with no pending request, or as a request whose result never arrives.

// File: rtl/lsbc_pkg.sv
package lsbc_pkg;
  localparam int FLAG_N  = 6;
  localparam int F_CARRY = 0;
  localparam int F_ZERO  = 1;
  localparam int F_SIGN  = 2;
  localparam int F_OVF   = 3;
  localparam int F_AUX   = 4;
  localparam int F_PAR   = 5;
  localparam logic [FLAG_N-1:0] DEFINED_MASK = 6'b001111;

  typedef struct packed {
    logic load;
    logic isWide;
    logic fault;
  } ctrlStrobes_t;
endpackage

// File: rtl/lsbc_ctrl.sv
module lsbc_ctrl
  import lsbc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         longMode,
  input  logic         legacyMode,
  input  logic         widthBit,
  input  logic         vecLenBit,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.load   = inValid;
    strobes.isWide = longMode & widthBit;
    strobes.fault  = vecLenBit | legacyMode;
  end

  // R3: wide operation never outside 64-bit mode
  a_r3_wide_needs_long: assert property (@(posedge clk) disable iff (rst)
    strobes.isWide |-> longMode);
  // R7 R8: a fault is only raised by an illegal encoding or mode
  a_r7_fault_source: assert property (@(posedge clk) disable iff (rst)
    (!vecLenBit && !legacyMode) |-> !strobes.fault);
endmodule

// File: rtl/lsbc_datapath.sv
module lsbc_datapath
  import lsbc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] srcOperand,
  output logic              outValid,
  output logic [DATA_W-1:0] resultData,
  output logic [FLAG_N-1:0] flagsOut,
  output logic [FLAG_N-1:0] flagsDefined,
  output logic              excUndef
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] cleared;
  logic [FLAG_N-1:0] nextFlags;

  always_comb begin
    opnd = strobes.isWide ? srcOperand
                          : {{(DATA_W-HALF_W){1'b0}}, srcOperand[HALF_W-1:0]};
    cleared = opnd & (opnd - 1'b1);
    nextFlags          = '0;
    nextFlags[F_CARRY] = (opnd == '0);
    nextFlags[F_ZERO]  = (cleared == '0);
    nextFlags[F_SIGN]  = strobes.isWide ? cleared[DATA_W-1] : cleared[HALF_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid     <= 1'b0;
      excUndef     <= 1'b0;
      resultData   <= '0;
      flagsOut     <= '0;
      flagsDefined <= '0;
    end else begin
      outValid <= strobes.load;
      excUndef <= strobes.load & strobes.fault;
      if (strobes.load) begin
        if (strobes.fault) begin
          resultData   <= '0;
          flagsOut     <= '0;
          flagsDefined <= '0;
        end else begin
          resultData   <= cleared;
          flagsOut     <= nextFlags;
          flagsDefined <= DEFINED_MASK;
        end
      end
    end
  end

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> outValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> !outValid);
  a_r7_fault_suppress: assert property (@(posedge clk) disable iff (rst)
    excUndef |-> (resultData == '0 && flagsDefined == '0));
  a_r6_overflow_clear: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !flagsOut[F_OVF]);
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (outValid && !excUndef) |-> (flagsOut[F_ZERO] == (resultData == '0)));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && !strobes.isWide) |=> (resultData[DATA_W-1:HALF_W] == '0));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && !excUndef));
endmodule

// File: rtl/lsb_clear_unit.sv
module lsb_clear_unit
  import lsbc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic              longMode,
  input  logic              legacyMode,
  input  logic              widthBit,
  input  logic              vecLenBit,
  output logic              outValid,
  output logic [DATA_W-1:0] resultData,
  output logic [5:0]        flagsOut,
  output logic [5:0]        flagsDefined,
  output logic              excUndef
);
  ctrlStrobes_t strobes;

  lsbc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .longMode(longMode),
    .legacyMode(legacyMode), .widthBit(widthBit), .vecLenBit(vecLenBit),
    .strobes(strobes)
  );

  lsbc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .srcOperand(srcOperand),
    .outValid(outValid), .resultData(resultData), .flagsOut(flagsOut),
    .flagsDefined(flagsDefined), .excUndef(excUndef)
  );
endmodule

// File: tb/lsb_clear_unit_bench.sv
module lsb_clear_unit_bench;
  logic clk = 0;
  logic rst = 1;
  logic inValid = 0;
  logic [63:0] srcOperand = '0;
  logic longMode = 0, legacyMode = 0, widthBit = 0, vecLenBit = 0;
  logic outValid, excUndef;
  logic [63:0] resultData;
  logic [5:0] flagsOut, flagsDefined;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [63:0] res;
    logic [5:0]  flg;
    logic [5:0]  def;
    logic        exc;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  lsb_clear_unit u_lsb_clear_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .srcOperand(srcOperand),
    .longMode(longMode), .legacyMode(legacyMode), .widthBit(widthBit),
    .vecLenBit(vecLenBit), .outValid(outValid), .resultData(resultData),
    .flagsOut(flagsOut), .flagsDefined(flagsDefined), .excUndef(excUndef)
  );

  function automatic expItem_t model(logic [63:0] s, logic lm, logic leg,
                                     logic wb, logic vl, string tag);
    expItem_t e;
    logic wide;
    logic [63:0] o, r;
    e.tag = tag;
    wide = lm & wb;
    if (vl || leg) begin
      e.res = '0; e.flg = '0; e.def = '0; e.exc = 1'b1;
    end else begin
      o = wide ? s : {32'h0, s[31:0]};
      r = o & (o - 64'd1);
      e.res = r;
      e.flg = {1'b0, 1'b0, 1'b0, (wide ? r[63] : r[31]), (r == 0), (o == 0)};
      e.def = 6'b001111;
      e.exc = 1'b0;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic drive(input logic [63:0] s, input logic lm, input logic leg,
                       input logic wb, input logic vl, input string tag);
    @(negedge clk);
    inValid = 1; srcOperand = s; longMode = lm; legacyMode = leg;
    widthBit = wb; vecLenBit = vl;
    expQ.push_back(model(s, lm, leg, wb, vl, tag));
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic driveBurst(input logic [63:0] s, input logic lm, input string tag);
    inValid = 1; srcOperand = s; longMode = lm; legacyMode = 0;
    widthBit = 1; vecLenBit = 0;
    expQ.push_back(model(s, lm, 1'b0, 1'b1, 1'b0, tag));
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst && outValid) begin
      if (expQ.size() == 0) begin
        check(0, $sformatf("R9 outValid with no pending request act=1 exp=0"));
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resultData == e.res, $sformatf("%s result act=%h exp=%h", e.tag, resultData, e.res));
        check(flagsOut == e.flg, $sformatf("%s flags act=%b exp=%b", e.tag, flagsOut, e.flg));
        check(flagsDefined == e.def, $sformatf("%s defined act=%b exp=%b", e.tag, flagsDefined, e.def));
        check(excUndef == e.exc, $sformatf("%s exc act=%b exp=%b", e.tag, excUndef, e.exc));
      end
    end
  end

  initial begin
    #200000;
    check(0, "watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    repeat (3) @(negedge clk);
    check(outValid == 0 && excUndef == 0,
          $sformatf("R10 reset state act=%b%b exp=00", outValid, excUndef));
    rst = 0;
    // R1 64-bit
    drive(64'h0000_00F0_0000_0000, 1, 0, 1, 0, "R1 wide mid");
    drive(64'hC000_0000_0000_0000, 1, 0, 1, 0, "R5 wide sign");
    // R11 corners
    drive(64'h0, 1, 0, 1, 0, "R11 zero wide");
    drive(64'h8000_0000_0000_0000, 1, 0, 1, 0, "R11 msb only wide");
    drive(64'h0, 0, 0, 0, 0, "R4 zero narrow");
    drive(64'h0000_0000_8000_0000, 1, 0, 0, 0, "R11 msb only narrow");
    // R2 upper bits ignored in 32-bit
    drive(64'hDEAD_BEEF_0000_0000, 1, 0, 0, 0, "R2 upper garbage");
    drive(64'hFFFF_FFFF_C000_0000, 1, 0, 0, 0, "R2 narrow sign");
    // R3 width bit ignored outside 64-bit mode
    drive(64'hFFFF_0000_0000_0100, 0, 0, 1, 0, "R3 width ignored");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, "R6 all ones");
    // R7 / R8 faults
    drive(64'h1234_5678_9ABC_DEF0, 1, 0, 1, 1, "R7 vector length");
    drive(64'h1234_5678_9ABC_DEF0, 0, 1, 0, 0, "R8 legacy mode");
    drive(64'h0000_0000_0000_0006, 1, 0, 1, 0, "R9 after fault");
    // R9 back to back
    @(negedge clk);
    lfsr = 64'hACE1_2468_1357_BEEF;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      driveBurst(lfsr, i[0], "R9 burst");
    end
    inValid = 0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, $sformatf("R9 pending act=%0d exp=0", expQ.size()));
    // R10 reset overrides a request
    @(negedge clk);
    rst = 1; inValid = 1; srcOperand = 64'h0; legacyMode = 1;
    @(posedge clk); #1;
    check(outValid == 0 && excUndef == 0,
          $sformatf("R10 reset with request act=%b%b exp=00", outValid, excUndef));
    @(negedge clk);
    rst = 0; inValid = 0; legacyMode = 0;
    drive(64'h0000_0000_0000_0018, 0, 0, 0, 0, "R2 after reset");
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, $sformatf("R9 final pending act=%0d exp=0", expQ.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule